// File: doc/BRIEF.md
# Short-Space Diagnostic Register Slave

This block is the register side of a bus monitor board. It answers short-address (16-bit) cycles on a parallel backplane bus. It occupies a 256-byte window whose base is set by eight jumper inputs. Inside the window it offers the following registers:

- a control word that mirrors and extends the front-panel switches;
- a status word that reports the switches, the software bits and a combined clock-and-power health flag;
- an interrupt/timeout configuration word;
- a command word that reads back the captured bus control lines;
- two views of the captured address;
- a 32-bit scratch data register with byte, word and longword lanes;
- a 32-bit test counter.

Bus capture, the interrupter and the missing-acknowledge watchdog live outside the block. Their values reach it only through ports.

A single state machine paces every accepted cycle. The states are:

- **IDLE** waits for a hit. Its transition *accept* goes to WAIT.
- **WAIT** counts clocks. Its transition *lead* goes to DATA, where read data is latched and driven. Its transition *abort* goes back to IDLE when both data strobes negate early.
- **DATA** keeps counting. Its transition *complete* goes to ACK, where writes and counter updates take effect. It also has an *abort* transition to IDLE.
- **ACK** holds the acknowledge low. Its transition *release* goes to IDLE once both strobes are high.

At a 100 MHz clock, the default timing places the acknowledge 120 ns after acceptance, and read data is on the bus 60 ns before it.

Top module: `vme_diag_slave`

## Requirements
- R1: A cycle is accepted only when `short_en` is 1, `as_n` is 0, at least one `ds_n` bit is 0, `am` is 0x29 or 0x2D, and `addr[15:8]` equals `base_jmp`. Otherwise `dtack_n` stays 1 and `data_oe` stays 0.
- R2: `dtack_n` falls exactly ACK_CYC (12) clocks after the accepting edge. On a read, `data_oe` rises LEAD_CYC (6) clocks before that, carrying the read value. A write never raises `data_oe`.
- R3: `dtack_n` stays 0 until both `ds_n` bits are 1, and returns to 1 one clock later. If both strobes negate before the acknowledge, the cycle is dropped: no acknowledge and no register effect.
- R4: A write to offset 0x00 stores D0 vd, D1 da, D2 eh, D4 endata and D7 halt. Each `mode_*` output is the OR of its switch and its stored bit. `soft_halt` is D7 alone. After reset, all stored bits are 0.
- R5: A read of 0x00 returns the stored bits at D0, D1, D2, D4 and D7, with D3 read as 0. It returns the switches vd, da, eh, rh and endata at D8 to D12, and the health flag at D15. The health flag is `sysclk_ok & p5_ok & p12_ok & n12_ok & ~p5_over`.
- R6: Offset 0x10 stores 14 bits: vector D7..D0, level D10..D8, mode D11 and timeout code D13..D12. It reads back with D15..D14 as 0. `tmo_code` is forced to 0 while `short_en` is 0.
- R7: A write to offset 0x20 gives a one-clock `soft_irq` pulse when D1 is 1, and a one-clock `irq_clr` pulse when D0 is 1. A read of 0x20 returns `cap_ctrl`.
- R8: A word read of 0x30 returns `{cap_addr[15:1],0}`. A longword read returns `{cap_addr[31:1],0}`. A read of 0x32 returns sysclk, +5 V ok, +12 V ok and -12 V ok at D15..D12, the +5 V overvoltage flag at D11, and `cap_addr[23:16]` at D7..D0.
- R9: Offsets 0x40 to 0x7F address the data register. A longword (`lword_n` = 0) writes D31..D0. Otherwise `ds_n[1]` = 0 writes D15..D8 and `ds_n[0]` = 0 writes D7..D0. A longword read returns all 32 bits; other reads return D15..D0 with zero above.
- R10: A longword access at a word offset (0x00) is accepted. D31..D16 of the write data are ignored, and D31..D16 of the read data are 0.
- R11: Offsets 0x80 to 0xFF address the counter. Any write clears it to 0. Every read returns the current value and then adds 1.
- R12: Offsets with no register complete with the normal acknowledge, read as 0, and ignore writes.
- R13: Control bit D3 is not stored. Writing it gives a one-clock pulse on `mode_rh`, which is also high whenever `sw_rh` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| short_en | input | 1 | Short-window enable switch |
| base_jmp | input | 8 | Jumper base address, compared with A15..A8 |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 2 | Data strobes; bit 1 upper lane, bit 0 lower lane |
| write_n | input | 1 | 0 = write cycle |
| lword_n | input | 1 | 0 = longword cycle |
| am | input | 6 | Address modifier |
| addr | input | 15 | Address bits A15..A1 |
| data_in | input | 32 | Bus data in |
| data_out | output | 32 | Read data, zero while not driven |
| data_oe | output | 1 | Read data output enable |
| dtack_n | output | 1 | Acknowledge, active low |
| sw_vd | input | 1 | Panel switch: acknowledge-on-timeout mode |
| sw_da | input | 1 | Panel switch: display-all mode |
| sw_eh | input | 1 | Panel switch: halt-on-error mode |
| sw_rh | input | 1 | Panel button: release halt |
| sw_endata | input | 1 | Switch: supply data on timeout |
| sysclk_ok | input | 1 | System clock present |
| p5_ok | input | 1 | +5 V above threshold |
| p12_ok | input | 1 | +12 V above threshold |
| n12_ok | input | 1 | -12 V below threshold |
| p5_over | input | 1 | +5 V overvoltage |
| cap_ctrl | input | 16 | Captured bus control lines |
| cap_addr | input | 31 | Captured address A31..A1 |
| mode_vd | output | 1 | Effective acknowledge-on-timeout mode |
| mode_da | output | 1 | Effective display-all mode |
| mode_eh | output | 1 | Effective halt-on-error mode |
| mode_rh | output | 1 | Release-halt request |
| mode_endata | output | 1 | Effective data-on-timeout mode |
| soft_halt | output | 1 | Software freeze of the capture registers |
| irq_vec | output | 8 | Interrupt vector |
| irq_lvl | output | 3 | Interrupt level |
| irq_mode | output | 1 | Interrupt release mode |
| tmo_code | output | 2 | Timeout selection code |
| soft_irq | output | 1 | Software interrupt request pulse |
| irq_clr | output | 1 | Interrupt flip-flop clear pulse |

## Verification
The hardest case to reach is a cycle whose strobes negate after acceptance but before the acknowledge. The block must then drop the access without side effects and must not re-accept while the address strobe is still low. The stimulus reaches this case by starting a longword write to the data register and raising both strobes four clocks in, while the address strobe stays low. It then watches the acknowledge for twenty clocks and reads the data register back, expecting it unchanged. The counter's read-then-increment order is reached by back-to-back reads at different offsets in the counter range, each expected to return one more than the last.

// File: rtl/vme_diag_pkg.sv
package vme_diag_pkg;

    localparam int DW = 32;
    localparam int HW = 16;

    localparam logic [5:0] AM_SHORT_USER = 6'h29;
    localparam logic [5:0] AM_SHORT_SUPV = 6'h2D;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DATA,
        ST_ACK
    } bus_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_ITC,
        SEL_IRQ,
        SEL_ADRLO,
        SEL_ADRHI,
        SEL_DATA,
        SEL_CNT
    } reg_sel_e;

    typedef struct packed {
        logic halt;
        logic endata;
        logic eh;
        logic da;
        logic vd;
    } ctrl_t;

endpackage

// File: rtl/vme_diag_decode.sv
module vme_diag_decode
    import vme_diag_pkg::*;
(
    input  logic        short_en,
    input  logic [7:0]  base_jmp,
    input  logic        as_n,
    input  logic [1:0]  ds_n,
    input  logic [5:0]  am,
    input  logic [15:1] addr,
    output logic        hit,
    output reg_sel_e    sel
);

    logic am_ok;
    logic base_ok;

    assign am_ok   = (am == AM_SHORT_USER) || (am == AM_SHORT_SUPV);
    assign base_ok = (addr[15:8] == base_jmp);
    assign hit     = short_en && !as_n && (ds_n != 2'b11) && am_ok && base_ok;

    always_comb begin
        sel = SEL_NONE;
        if (addr[7]) begin
            sel = SEL_CNT;
        end else if (addr[6]) begin
            sel = SEL_DATA;
        end else begin
            case (addr[5:1])
                5'h00:   sel = SEL_CTRL;
                5'h08:   sel = SEL_ITC;
                5'h10:   sel = SEL_IRQ;
                5'h18:   sel = SEL_ADRLO;
                5'h19:   sel = SEL_ADRHI;
                default: sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/vme_diag_ctl.sv
module vme_diag_ctl
    import vme_diag_pkg::*;
#(
    parameter int ACK_CYC  = 12,
    parameter int LEAD_CYC = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic [1:0] ds_n,
    input  logic       write_n,
    output logic       accept,
    output logic       latch_rd,
    output logic       commit,
    output logic       dtack_n,
    output logic       data_oe
);

    localparam int             TW      = $clog2(ACK_CYC + 1);
    localparam logic [TW-1:0]  LEAD_AT = TW'(ACK_CYC - LEAD_CYC - 1);
    localparam logic [TW-1:0]  ACK_AT  = TW'(ACK_CYC - 1);

    bus_state_e    state, state_nx;
    logic [TW-1:0] tmr;
    logic          rd_q;
    logic          ds_idle;

    assign ds_idle = (ds_n == 2'b11);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (hit) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (ds_idle)             state_nx = ST_IDLE;
                else if (tmr == LEAD_AT) state_nx = ST_DATA;
            end
            ST_DATA: begin
                if (ds_idle)            state_nx = ST_IDLE;
                else if (tmr == ACK_AT) state_nx = ST_ACK;
            end
            ST_ACK:  if (ds_idle) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tmr   <= '0;
            rd_q  <= 1'b0;
        end else begin
            state <= state_nx;
            tmr   <= (state == ST_IDLE) ? '0 : tmr + TW'(1);
            if (accept) rd_q <= write_n;
        end
    end

    always_comb begin
        accept   = 1'b0;
        latch_rd = 1'b0;
        commit   = 1'b0;
        dtack_n  = 1'b1;
        data_oe  = 1'b0;
        unique case (state)
            ST_IDLE: accept   = hit;
            ST_WAIT: latch_rd = !ds_idle && (tmr == LEAD_AT);
            ST_DATA: begin
                commit  = !ds_idle && (tmr == ACK_AT);
                data_oe = rd_q;
            end
            ST_ACK: begin
                dtack_n = 1'b0;
                data_oe = rd_q;
            end
        endcase
    end

endmodule

// File: rtl/vme_diag_regs.sv
module vme_diag_regs
    import vme_diag_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          latch_rd,
    input  logic          commit,
    input  reg_sel_e      sel_in,
    input  logic          write_n,
    input  logic          lword_n,
    input  logic [1:0]    ds_n,
    input  logic [DW-1:0] data_in,
    input  logic          sw_vd,
    input  logic          sw_da,
    input  logic          sw_eh,
    input  logic          sw_rh,
    input  logic          sw_endata,
    input  logic          sysclk_ok,
    input  logic          p5_ok,
    input  logic          p12_ok,
    input  logic          n12_ok,
    input  logic          p5_over,
    input  logic [HW-1:0] cap_ctrl,
    input  logic [31:1]   cap_addr,
    output logic [DW-1:0] rdata,
    output ctrl_t         ctrl,
    output logic [13:0]   itcfg,
    output logic          rh_pulse,
    output logic          sirq_pulse,
    output logic          iclr_pulse
);

    reg_sel_e      sel_q;
    logic          wr_q;
    logic          lwn_q;
    logic [1:0]    ds_q;
    logic [DW-1:0] dreg;
    logic [DW-1:0] cnt;
    logic [DW-1:0] rd_mux;
    logic          health;

    assign health = sysclk_ok & p5_ok & p12_ok & n12_ok & ~p5_over;

    always_comb begin
        rd_mux = '0;
        unique case (sel_q)
            SEL_NONE:  rd_mux = '0;
            SEL_CTRL:  rd_mux = {16'h0, health, 2'b00,
                                 sw_endata, sw_rh, sw_eh, sw_da, sw_vd,
                                 ctrl.halt, 2'b00, ctrl.endata, 1'b0,
                                 ctrl.eh, ctrl.da, ctrl.vd};
            SEL_ITC:   rd_mux = {18'h0, itcfg};
            SEL_IRQ:   rd_mux = {16'h0, cap_ctrl};
            SEL_ADRLO: rd_mux = lwn_q ? {16'h0, cap_addr[15:1], 1'b0}
                                      : {cap_addr[31:1], 1'b0};
            SEL_ADRHI: rd_mux = {16'h0, sysclk_ok, p5_ok, p12_ok, n12_ok,
                                 p5_over, 3'b000, cap_addr[23:16]};
            SEL_DATA:  rd_mux = lwn_q ? {16'h0, dreg[15:0]} : dreg;
            SEL_CNT:   rd_mux = lwn_q ? {16'h0, cnt[15:0]} : cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q      <= SEL_NONE;
            wr_q       <= 1'b0;
            lwn_q      <= 1'b1;
            ds_q       <= 2'b11;
            rdata      <= '0;
            ctrl       <= '0;
            itcfg      <= '0;
            dreg       <= '0;
            cnt        <= '0;
            rh_pulse   <= 1'b0;
            sirq_pulse <= 1'b0;
            iclr_pulse <= 1'b0;
        end else begin
            rh_pulse   <= 1'b0;
            sirq_pulse <= 1'b0;
            iclr_pulse <= 1'b0;
            if (accept) begin
                sel_q <= sel_in;
                wr_q  <= !write_n;
                lwn_q <= lword_n;
                ds_q  <= ds_n;
            end
            if (latch_rd) rdata <= rd_mux;
            if (commit && wr_q) begin
                unique case (sel_q)
                    SEL_CTRL: begin
                        ctrl.vd     <= data_in[0];
                        ctrl.da     <= data_in[1];
                        ctrl.eh     <= data_in[2];
                        rh_pulse    <= data_in[3];
                        ctrl.endata <= data_in[4];
                        ctrl.halt   <= data_in[7];
                    end
                    SEL_ITC: itcfg <= data_in[13:0];
                    SEL_IRQ: begin
                        sirq_pulse <= data_in[1];
                        iclr_pulse <= data_in[0];
                    end
                    SEL_DATA: begin
                        if (!lwn_q) begin
                            dreg <= data_in;
                        end else begin
                            if (!ds_q[1]) dreg[15:8] <= data_in[15:8];
                            if (!ds_q[0]) dreg[7:0]  <= data_in[7:0];
                        end
                    end
                    SEL_CNT: cnt <= '0;
                    default: ;
                endcase
            end
            if (commit && !wr_q && (sel_q == SEL_CNT)) cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/vme_diag_slave.sv
module vme_diag_slave
    import vme_diag_pkg::*;
#(
    parameter int ACK_CYC  = 12,
    parameter int LEAD_CYC = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        short_en,
    input  logic [7:0]  base_jmp,
    input  logic        as_n,
    input  logic [1:0]  ds_n,
    input  logic        write_n,
    input  logic        lword_n,
    input  logic [5:0]  am,
    input  logic [15:1] addr,
    input  logic [31:0] data_in,
    output logic [31:0] data_out,
    output logic        data_oe,
    output logic        dtack_n,
    input  logic        sw_vd,
    input  logic        sw_da,
    input  logic        sw_eh,
    input  logic        sw_rh,
    input  logic        sw_endata,
    input  logic        sysclk_ok,
    input  logic        p5_ok,
    input  logic        p12_ok,
    input  logic        n12_ok,
    input  logic        p5_over,
    input  logic [15:0] cap_ctrl,
    input  logic [31:1] cap_addr,
    output logic        mode_vd,
    output logic        mode_da,
    output logic        mode_eh,
    output logic        mode_rh,
    output logic        mode_endata,
    output logic        soft_halt,
    output logic [7:0]  irq_vec,
    output logic [2:0]  irq_lvl,
    output logic        irq_mode,
    output logic [1:0]  tmo_code,
    output logic        soft_irq,
    output logic        irq_clr
);

    logic          hit;
    reg_sel_e      sel;
    logic          accept, latch_rd, commit;
    logic [DW-1:0] rdata;
    ctrl_t         ctrl;
    logic [13:0]   itcfg;
    logic          rh_pulse;

    vme_diag_decode u_decode (
        .short_en (short_en),
        .base_jmp (base_jmp),
        .as_n     (as_n),
        .ds_n     (ds_n),
        .am       (am),
        .addr     (addr),
        .hit      (hit),
        .sel      (sel)
    );

    vme_diag_ctl #(
        .ACK_CYC  (ACK_CYC),
        .LEAD_CYC (LEAD_CYC)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .ds_n     (ds_n),
        .write_n  (write_n),
        .accept   (accept),
        .latch_rd (latch_rd),
        .commit   (commit),
        .dtack_n  (dtack_n),
        .data_oe  (data_oe)
    );

    vme_diag_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .latch_rd   (latch_rd),
        .commit     (commit),
        .sel_in     (sel),
        .write_n    (write_n),
        .lword_n    (lword_n),
        .ds_n       (ds_n),
        .data_in    (data_in),
        .sw_vd      (sw_vd),
        .sw_da      (sw_da),
        .sw_eh      (sw_eh),
        .sw_rh      (sw_rh),
        .sw_endata  (sw_endata),
        .sysclk_ok  (sysclk_ok),
        .p5_ok      (p5_ok),
        .p12_ok     (p12_ok),
        .n12_ok     (n12_ok),
        .p5_over    (p5_over),
        .cap_ctrl   (cap_ctrl),
        .cap_addr   (cap_addr),
        .rdata      (rdata),
        .ctrl       (ctrl),
        .itcfg      (itcfg),
        .rh_pulse   (rh_pulse),
        .sirq_pulse (soft_irq),
        .iclr_pulse (irq_clr)
    );

    assign data_out    = data_oe ? rdata : '0;
    assign mode_vd     = sw_vd | ctrl.vd;
    assign mode_da     = sw_da | ctrl.da;
    assign mode_eh     = sw_eh | ctrl.eh;
    assign mode_endata = sw_endata | ctrl.endata;
    assign mode_rh     = sw_rh | rh_pulse;
    assign soft_halt   = ctrl.halt;
    assign irq_vec     = itcfg[7:0];
    assign irq_lvl     = itcfg[10:8];
    assign irq_mode    = itcfg[11];
    assign tmo_code    = short_en ? itcfg[13:12] : 2'b00;

endmodule

// File: rtl/vme_diag_chk.sv
module vme_diag_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       short_en,
    input logic [5:0] am,
    input logic [1:0] ds_n,
    input logic       write_n,
    input logic       data_oe,
    input logic       dtack_n
);

    AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n) data_oe |-> write_n); // R2
    AST_OE_LEADS_ACK: assert property (@(posedge clk) disable iff (!rst_n) ($fell(dtack_n) && write_n) |-> $past(data_oe)); // R2
    AST_ACK_GATED: assert property (@(posedge clk) disable iff (!rst_n) $fell(dtack_n) |-> (short_en && (am == 6'h29 || am == 6'h2D))); // R1
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!dtack_n && ds_n != 2'b11) |=> !dtack_n); // R3
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (!dtack_n && ds_n == 2'b11) |=> dtack_n); // R3
    AST_NO_ACK_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (dtack_n && ds_n == 2'b11) |=> dtack_n); // R3

endmodule

bind vme_diag_slave vme_diag_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .short_en (short_en),
    .am       (am),
    .ds_n     (ds_n),
    .write_n  (write_n),
    .data_oe  (data_oe),
    .dtack_n  (dtack_n)
);

// File: tb/vme_diag_slave_tb_top.sv
module vme_diag_slave_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        short_en = 1'b1;
    logic [7:0]  base_jmp = 8'h88;
    logic        as_n = 1'b1;
    logic [1:0]  ds_n = 2'b11;
    logic        write_n = 1'b1;
    logic        lword_n = 1'b1;
    logic [5:0]  am = 6'h29;
    logic [15:1] addr = '0;
    logic [31:0] data_in = '0;
    logic [31:0] data_out;
    logic        data_oe, dtack_n;
    logic        sw_vd = 0, sw_da = 0, sw_eh = 1, sw_rh = 0, sw_endata = 0;
    logic        sysclk_ok = 1, p5_ok = 1, p12_ok = 1, n12_ok = 1, p5_over = 0;
    logic [15:0] cap_ctrl = 16'hA5C3;
    logic [31:1] cap_addr = 31'h44D5E6F7;
    logic        mode_vd, mode_da, mode_eh, mode_rh, mode_endata, soft_halt;
    logic [7:0]  irq_vec;
    logic [2:0]  irq_lvl;
    logic        irq_mode;
    logic [1:0]  tmo_code;
    logic        soft_irq, irq_clr;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int n_rh = 0, n_sirq = 0, n_iclr = 0;
    bit done = 0;

    logic        q_rd[$];
    logic [31:0] q_exp[$];
    int          q_start[$];
    string       q_req[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vme_diag_slave dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops scoreboard items when the acknowledge falls.
    logic prev_dt = 1'b1, prev_oe = 1'b0;
    int   oe_rise = 0;
    always @(negedge clk) begin
        if (mode_rh)  n_rh++;
        if (soft_irq) n_sirq++;
        if (irq_clr)  n_iclr++;
        if (!prev_oe && data_oe) oe_rise = cyc;
        if (prev_dt && !dtack_n) begin
            if (q_rd.size() == 0) begin
                chk(0, "R1 unexpected ack", 32'(cyc), 0);
            end else begin
                automatic logic  rd  = q_rd.pop_front();
                automatic logic [31:0] ex = q_exp.pop_front();
                automatic int    st  = q_start.pop_front();
                automatic string rq  = q_req.pop_front();
                chk((cyc - st) == 13, {"R2 ack latency ", rq}, 32'(cyc - st), 13);
                if (rd) begin
                    chk(data_oe && data_out == ex, rq, data_out, ex);
                    chk((cyc - oe_rise) == 6, {"R2 data lead ", rq}, 32'(cyc - oe_rise), 6);
                end else begin
                    chk(!data_oe, {"R2 no drive on write ", rq}, 32'(data_oe), 0);
                end
            end
        end
        prev_dt = dtack_n;
        prev_oe = data_oe;
    end

    task automatic access(input bit wr, input bit lw, input logic [1:0] ds, input logic [5:0] amv,
                          input logic [15:0] adr, input logic [31:0] wdat, input logic [31:0] exp,
                          input string req);
        bit got = 0;
        @(negedge clk);
        as_n = 0; ds_n = ds; write_n = !wr; lword_n = !lw; am = amv;
        addr = adr[15:1]; data_in = wdat;
        q_rd.push_back(!wr); q_exp.push_back(exp); q_start.push_back(cyc); q_req.push_back(req);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!dtack_n) begin got = 1; break; end
        end
        if (!got) begin
            chk(0, {"R2 no ack ", req}, 1, 0);
            void'(q_rd.pop_front()); void'(q_exp.pop_front());
            void'(q_start.pop_front()); void'(q_req.pop_front());
        end
        @(negedge clk);
        as_n = 1; ds_n = 2'b11; data_in = '0;
        @(negedge clk);
        chk(dtack_n == 1'b1, {"R3 release ", req}, 32'(dtack_n), 1);
    endtask

    task automatic rd(input logic [15:0] adr, input bit lw, input logic [31:0] exp, input string req);
        access(0, lw, 2'b00, 6'h29, adr, 32'h0, exp, req);
    endtask

    task automatic wr(input logic [15:0] adr, input bit lw, input logic [1:0] ds, input logic [31:0] d, input string req);
        access(1, lw, ds, 6'h29, adr, d, 32'h0, req);
    endtask

    task automatic no_ack(input logic [5:0] amv, input logic [15:0] adr, input string req);
        bit seen = 0;
        @(negedge clk);
        as_n = 0; ds_n = 2'b00; write_n = 1; lword_n = 1; am = amv; addr = adr[15:1];
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!dtack_n || data_oe) seen = 1;
        end
        chk(!seen, req, 32'(seen), 0);
        as_n = 1; ds_n = 2'b11; am = 6'h29;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state
        chk(dtack_n && !data_oe, "R2 reset bus idle", {dtack_n, data_oe}, 2'b10);
        chk({mode_vd, mode_da, soft_halt, mode_endata} == 4'b0, "R4 reset modes", {mode_vd, mode_da, soft_halt, mode_endata}, 0);
        rd(16'h8840, 1, 32'h0, "R9 reset data reg");

        // Status and health
        rd(16'h8800, 0, 32'h0000_8400, "R5 status healthy");
        p5_over = 1;
        rd(16'h8800, 0, 32'h0000_0400, "R5 status overvoltage");

        // Control register and OR of modes
        n_rh = 0;
        wr(16'h8800, 0, 2'b00, 32'h0000_009B, "R4 ctrl write");
        chk({mode_vd, mode_da, mode_eh, mode_endata, soft_halt} == 5'b11111, "R4 effective modes",
            {mode_vd, mode_da, mode_eh, mode_endata, soft_halt}, 5'b11111);
        chk(n_rh == 1, "R13 release pulse width", n_rh, 1);
        rd(16'h8800, 0, 32'h0000_0493, "R13 status rh not stored");
        wr(16'h8800, 1, 2'b00, 32'hFFFF_0000, "R10 longword ctrl write");
        chk({mode_vd, mode_da, mode_eh, soft_halt} == 4'b0010, "R10 upper data ignored",
            {mode_vd, mode_da, mode_eh, soft_halt}, 4'b0010);
        rd(16'h8800, 1, 32'h0000_0400, "R10 longword status read");
        p5_over = 0;

        // Interrupt / timeout configuration
        wr(16'h8810, 0, 2'b00, 32'h0000_FF5A, "R6 itcfg write");
        rd(16'h8810, 0, 32'h0000_3F5A, "R6 itcfg read");
        chk({tmo_code, irq_mode, irq_lvl, irq_vec} == {2'd3, 1'b1, 3'd7, 8'h5A}, "R6 itcfg outputs",
            {tmo_code, irq_mode, irq_lvl, irq_vec}, {2'd3, 1'b1, 3'd7, 8'h5A});
        short_en = 0;
        @(negedge clk);
        chk(tmo_code == 2'b00, "R6 timeout forced", tmo_code, 0);
        no_ack(6'h29, 16'h8800, "R1 short window disabled");
        short_en = 1;

        // Software interrupt command and captured control
        n_sirq = 0; n_iclr = 0;
        wr(16'h8820, 0, 2'b00, 32'h0000_0002, "R7 soft irq");
        chk(n_sirq == 1 && n_iclr == 0, "R7 soft irq pulse", {n_sirq[15:0], n_iclr[15:0]}, 32'h0001_0000);
        wr(16'h8820, 0, 2'b00, 32'h0000_0001, "R7 irq clear");
        chk(n_sirq == 1 && n_iclr == 1, "R7 clear pulse", {n_sirq[15:0], n_iclr[15:0]}, 32'h0001_0001);
        rd(16'h8820, 0, 32'h0000_A5C3, "R7 captured control");

        // Captured address views (cap_addr = A31..A1 of 0x89ABCDEE)
        rd(16'h8830, 0, 32'h0000_CDEE, "R8 address word");
        rd(16'h8830, 1, 32'h89AB_CDEE, "R8 address longword");
        rd(16'h8832, 0, 32'h0000_F0AB, "R8 power and A23..A16");

        // Data register lanes
        wr(16'h8840, 1, 2'b00, 32'h1234_5678, "R9 longword write");
        rd(16'h8840, 1, 32'h1234_5678, "R9 longword read");
        wr(16'h8844, 0, 2'b00, 32'h5555_BEEF, "R9 word write");
        rd(16'h887C, 1, 32'h1234_BEEF, "R9 word lanes");
        wr(16'h8848, 0, 2'b01, 32'h0000_7700, "R9 upper byte write");
        wr(16'h8849, 0, 2'b10, 32'h0000_0011, "R9 lower byte write");
        rd(16'h8840, 1, 32'h1234_7711, "R9 byte lanes");
        rd(16'h8840, 0, 32'h0000_7711, "R9 word read");

        // Test counter
        wr(16'h8880, 0, 2'b00, 32'hFFFF_FFFF, "R11 clear");
        rd(16'h8880, 0, 32'h0, "R11 first read");
        rd(16'h88FC, 0, 32'h1, "R11 second read");
        rd(16'h8884, 1, 32'h2, "R11 longword read");
        wr(16'h8884, 1, 2'b00, 32'h0, "R11 clear again");
        rd(16'h8880, 1, 32'h0, "R11 after clear");

        // Unmapped offsets
        rd(16'h8804, 0, 32'h0, "R12 unmapped read");
        wr(16'h8802, 0, 2'b00, 32'h0000_FFFF, "R12 unmapped write");
        rd(16'h8800, 0, 32'h0000_8400, "R12 write had no effect");

        // Gating
        no_ack(6'h39, 16'h8800, "R1 wrong modifier");
        no_ack(6'h29, 16'h8900, "R1 wrong base");
        access(0, 0, 2'b00, 6'h2D, 16'h8800, 0, 32'h0000_8400, "R1 supervisory modifier");

        // Abort: strobes released before acknowledge
        begin
            bit seen = 0;
            @(negedge clk);
            as_n = 0; ds_n = 2'b00; write_n = 0; lword_n = 0; am = 6'h29;
            addr = 15'(16'h8840 >> 1); data_in = 32'hDEAD_BEEF;
            repeat (4) @(negedge clk);
            ds_n = 2'b11;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (!dtack_n) seen = 1;
            end
            chk(!seen, "R3 abort no ack", 32'(seen), 0);
            as_n = 1; write_n = 1; lword_n = 1; data_in = 0;
            @(negedge clk);
        end
        rd(16'h8840, 1, 32'h1234_7711, "R3 abort no effect");

        repeat (3) @(negedge clk);
        chk(q_rd.size() == 0, "R2 scoreboard drained", q_rd.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule